// File: doc/BRIEF.md
# Vector Group Micro-op Sequencer

This block sits between instruction decode and the vector execution lanes. It takes one vector arithmetic instruction whose operands name register groups and splits it into a series of micro-ops. Each micro-op names one destination register and one or two source registers. A separate configuration write port records the current group-size code. Every instruction accepted afterwards is expanded according to that code.

An instruction enters through a valid/ready handshake. The block then owns it until its final micro-op has been taken on the output valid/ready handshake. Every micro-op carries:
- the operation code;
- the scalar or immediate operand, passed on without change;
- its register indices;
- a first marker and a last marker.

A widening instruction produces twice as many micro-ops, and its narrow source advances at half the rate of the other operands.

Top module: `lmul_uop_seq`

## Requirements
- R1: For a normal instruction with integer group-size code 0, 1, 2 or 3 (group of 1, 2, 4 or 8 registers), exactly that many micro-ops are emitted.
- R2: Group-size codes 4 to 7 (fractional, codes 5, 6 and 7 meaning 1/8, 1/4 and 1/2) emit exactly one micro-op, whether or not the instruction is widening.
- R3: A widening instruction (`in_wide`=1) with integer code k emits 2*2^k micro-ops. On micro-op i, the destination and source 2 are base+i and source 1 is base+floor(i/2).
- R4: The first micro-op uses the register indices given with the instruction. On a normal instruction each later micro-op raises the destination, source 1 and source 2 by one (modulo 2^REG_AW).
- R5: The scalar/immediate operand and the operation code are the same on every micro-op of an expansion.
- R6: An instruction uses the code held by the last `cfg_we` write that completed at an earlier clock edge. A write made during an expansion does not change that expansion.
- R7: `in_ready` is low from the edge that accepts an instruction until the edge on which its last micro-op is taken. No second instruction is accepted in that interval.
- R8: While `out_valid` is high and `out_ready` is low, every output field stays unchanged. The micro-op index advances only on a completed output handshake.
- R9: Only the first micro-op has `out_first` set and only the final one has `out_last` set. A one-micro-op expansion has both set.
- R10: After reset `out_valid` is 0, `in_ready` is 1, and the group-size code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the group-size code |
| cfg_lmul | input | 3 | Group-size code to record |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted |
| in_op | input | OPC_W | Operation code |
| in_wide | input | 1 | Widening instruction class |
| in_vd | input | REG_AW | Destination group base |
| in_vs1 | input | REG_AW | Source 1 group base (narrow source when widening) |
| in_vs2 | input | REG_AW | Source 2 group base |
| in_scalar | input | OPW | Scalar or immediate operand |
| out_valid | output | 1 | Micro-op offered |
| out_ready | input | 1 | Micro-op taken |
| out_op | output | OPC_W | Operation code |
| out_vd | output | REG_AW | Destination register |
| out_vs1 | output | REG_AW | Source 1 register |
| out_vs2 | output | REG_AW | Source 2 register |
| out_scalar | output | OPW | Scalar or immediate operand |
| out_first | output | 1 | First micro-op of the expansion |
| out_last | output | 1 | Last micro-op of the expansion |

## Verification
The properties assume the upstream decoder has already rejected illegal configurations: no widening instruction at code 3, and no misaligned group bases. They also assume register indices wrap modulo the register count, which can only happen when the bases lie near the top of the file. The stimulus keeps within these limits. Widening is never combined with code 3, and every base is rounded down to a multiple of the effective group size. The bench varies the valid and ready timing at random, writes configuration immediately before an issue and in the middle of an expansion, and covers every code in both instruction classes.

// File: rtl/lmul_uop_seq.sv
module lmul_uop_seq #(
  parameter int REG_AW = 5,
  parameter int OPW    = 32,
  parameter int OPC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_lmul,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_op,
  input  logic              in_wide,
  input  logic [REG_AW-1:0] in_vd,
  input  logic [REG_AW-1:0] in_vs1,
  input  logic [REG_AW-1:0] in_vs2,
  input  logic [OPW-1:0]    in_scalar,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OPC_W-1:0]  out_op,
  output logic [REG_AW-1:0] out_vd,
  output logic [REG_AW-1:0] out_vs1,
  output logic [REG_AW-1:0] out_vs2,
  output logic [OPW-1:0]    out_scalar,
  output logic              out_first,
  output logic              out_last
);
  localparam int CW = 5;

  logic [2:0]        lmul_q;
  logic              busy_q, wide_q;
  logic [CW-1:0]     idx_q, last_q, n_uops;
  logic [OPC_W-1:0]  op_q;
  logic [REG_AW-1:0] vd_q, vs1_q, vs2_q;
  logic [OPW-1:0]    sc_q;
  logic [CW-1:0]     vs1_off;

  wire in_fire  = in_valid && in_ready;
  wire out_fire = busy_q && out_ready;

  always_comb begin
    if (lmul_q[2]) n_uops = CW'(1);
    else           n_uops = CW'((5'd1 << lmul_q[1:0]) << in_wide);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lmul_q <= 3'd0;
    else if (cfg_we) lmul_q <= cfg_lmul;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      wide_q <= 1'b0;
      op_q   <= '0;
      vd_q   <= '0;
      vs1_q  <= '0;
      vs2_q  <= '0;
      sc_q   <= '0;
    end else if (in_fire) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      last_q <= n_uops - CW'(1);
      wide_q <= in_wide;
      op_q   <= in_op;
      vd_q   <= in_vd;
      vs1_q  <= in_vs1;
      vs2_q  <= in_vs2;
      sc_q   <= in_scalar;
    end else if (out_fire) begin
      if (idx_q == last_q) busy_q <= 1'b0;
      else                 idx_q  <= idx_q + CW'(1);
    end
  end

  assign vs1_off    = wide_q ? (idx_q >> 1) : idx_q;
  assign in_ready   = !busy_q;
  assign out_valid  = busy_q;
  assign out_op     = op_q;
  assign out_scalar = sc_q;
  assign out_vd     = vd_q  + REG_AW'(idx_q);
  assign out_vs2    = vs2_q + REG_AW'(idx_q);
  assign out_vs1    = vs1_q + REG_AW'(vs1_off);
  assign out_first  = busy_q && (idx_q == '0);
  assign out_last   = busy_q && (idx_q == last_q);
endmodule

module lmul_uop_seq_chk #(
  parameter int REG_AW = 5,
  parameter int OPW    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [REG_AW-1:0] out_vd,
  input logic [REG_AW-1:0] out_vs1,
  input logic [REG_AW-1:0] out_vs2,
  input logic [OPW-1:0]    out_scalar,
  input logic              out_first,
  input logic              out_last
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vd) && $stable(out_vs1)
      && $stable(out_vs2) && $stable(out_scalar) && $stable(out_first) && $stable(out_last));
  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R4
  vd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && out_vd == REG_AW'($past(out_vd) + 1'b1));
  // R5
  scalar_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_scalar == $past(out_scalar));
  // R9
  first_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_first);
  // R9
  no_first_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> !out_first);
  // R7
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && in_ready);
endmodule

bind lmul_uop_seq lmul_uop_seq_chk #(.REG_AW(REG_AW), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_vd(out_vd),
  .out_vs1(out_vs1), .out_vs2(out_vs2), .out_scalar(out_scalar),
  .out_first(out_first), .out_last(out_last)
);

// File: tb/tb_lmul_uop_seq.sv
`timescale 1ns/1ps
module tb_lmul_uop_seq;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_lmul = 0;
  logic in_valid = 0, in_ready, in_wide = 0, out_valid, out_ready = 0, out_first, out_last;
  logic [5:0] in_op = 0, out_op;
  logic [4:0] in_vd = 0, in_vs1 = 0, in_vs2 = 0, out_vd, out_vs1, out_vs2;
  logic [31:0] in_scalar = 0, out_scalar;

  always #2.5 clk = ~clk;

  lmul_uop_seq dut (.*);

  typedef struct packed {
    logic wide; logic [5:0] op; logic [4:0] vd, vs1, vs2;
    logic [31:0] sc; logic first, last;
  } uop_t;

  uop_t q[$];
  int checks = 0, fails = 0;
  logic [2:0] m_lmul = 0;
  bit accepted;

  task automatic fail(input string req, input string what, input longint act, input longint exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic cmp(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) fail(req, what, act, exp);
  endtask

  task automatic check_outputs();
    cmp("R7", "in_ready", in_ready, q.size() == 0);
    cmp("R1", "out_valid", out_valid, q.size() != 0);
    if (q.size() != 0 && out_valid) begin
      cmp("R4", "out_vd", out_vd, q[0].vd);
      cmp("R4", "out_vs2", out_vs2, q[0].vs2);
      cmp(q[0].wide ? "R3" : "R4", "out_vs1", out_vs1, q[0].vs1);
      cmp("R5", "out_scalar", out_scalar, q[0].sc);
      cmp("R5", "out_op", out_op, q[0].op);
      cmp("R9", "out_first", out_first, q[0].first);
      cmp("R9", "out_last", out_last, q[0].last);
    end
  endtask

  task automatic tick(input bit v, input bit w, input logic [4:0] d, s1, s2,
                      input logic [31:0] sc, input bit rdy, input bit cwe, input logic [2:0] cl);
    int n;
    uop_t u;
    @(negedge clk);
    check_outputs();
    in_valid = v; in_wide = w; in_vd = d; in_vs1 = s1; in_vs2 = s2;
    in_scalar = sc; in_op = sc[5:0] ^ 6'h2a; out_ready = rdy; cfg_we = cwe; cfg_lmul = cl;
    accepted = 0;
    if (q.size() != 0 && rdy) void'(q.pop_front());
    else if (q.size() == 0 && v) begin
      accepted = 1;
      n = m_lmul[2] ? 1 : ((1 << m_lmul[1:0]) * (w ? 2 : 1));
      for (int i = 0; i < n; i++) begin
        u.wide = w; u.op = sc[5:0] ^ 6'h2a; u.sc = sc;
        u.vd = d + 5'(i); u.vs2 = s2 + 5'(i);
        u.vs1 = w ? s1 + 5'(i / 2) : s1 + 5'(i);
        u.first = (i == 0); u.last = (i == n - 1);
        q.push_back(u);
      end
    end
    if (cwe) m_lmul = cl;
  endtask

  task automatic set_cfg(input logic [2:0] cl);
    tick(0, 0, 0, 0, 0, 0, 1, 1, cl);
  endtask

  task automatic issue(input bit w, input int rdy_pct, input bit mid_cfg, input logic [2:0] mid_val);
    int emul;
    logic [4:0] d, s1, s2;
    logic [31:0] sc;
    emul = m_lmul[2] ? 1 : (1 << m_lmul[1:0]) * (w ? 2 : 1);
    d  = 5'($urandom % 32) & ~5'(emul - 1);
    s2 = 5'($urandom % 32) & ~5'(emul - 1);
    s1 = 5'($urandom % 32) & ~5'(w ? emul / 2 - 1 + (emul == 1 ? 1 : 0) : emul - 1);
    sc = $urandom;
    do tick(1, w, d, s1, s2, sc, 0, 0, 0); while (!accepted);
    while (q.size() != 0) begin
      bit r;
      r = (($urandom % 100) < rdy_pct);
      // R6: a write in the middle of an expansion must not disturb it
      if (mid_cfg && q.size() == 2) tick(0, 0, 0, 0, 0, 0, r, 1, mid_val);
      else tick($urandom % 2, 0, 0, 0, 0, 0, r, 0, 0);
    end
    tick(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] codes[7] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd6, 3'd7};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    // R10: idle after reset
    cmp("R10", "in_ready after reset", in_ready, 1);
    cmp("R10", "out_valid after reset", out_valid, 0);
    // R10: default code 0 gives a single micro-op (R1)
    issue(0, 100, 0, 0);
    foreach (codes[k]) begin
      set_cfg(codes[k]);
      // R1/R2 normal class, full-rate and stalled outputs (R8)
      issue(0, 100, 0, 0);
      issue(0, 40, 0, 0);
      // R3 widening, never with code 3
      if (codes[k] != 3'd3) begin
        issue(1, 100, 0, 0);
        issue(1, 30, 0, 0);
      end
    end
    // R6: write mid-expansion, next instruction picks up the new code
    set_cfg(3'd2);
    issue(0, 60, 1, 3'd1);
    issue(0, 60, 0, 0);
    issue(1, 50, 1, 3'd6);
    issue(1, 100, 0, 0);
    for (int t = 0; t < 40; t++) begin
      logic [2:0] c;
      c = codes[$urandom % 7];
      set_cfg(c);
      issue((c != 3'd3) && ($urandom % 2 == 1), 50, 0, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule